// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is the control sequencer of a small single-accumulator processor. It walks the processor through the four phases of an instruction: fetch, indirect operand resolution, execute and interrupt entry. A two-bit phase code records where the machine is, and a timing-step counter counts the steps inside the phase. In every clock cycle the block raises the data-path gate enables and memory strobes that the current phase, the current step and the decoded opcode call for. The register file, the ALU and the memory sit outside and simply obey these enables.

Every control output is a sum of products of the phase code, a decoded step and a decoded opcode. The phase code and step counter are the only state. Each step lasts exactly one clock. The phase at the end of each phase is chosen from the indirect-address bit (after fetch) and from the interrupt request gated by the interrupt-enable flag (after execute). The interrupt-enable flag is held outside the block; the block pulses a clear enable when it takes an interrupt.

Gate bit positions used throughout: 0 PC to MAR, 1 memory to MBR, 2 PC increment, 3 MBR to IR, 4 IR address to MAR, 5 PC to MBR, 6 save address to MAR, 7 routine address to PC, 8 MBR to memory, 9 MBR increment, 10 accumulator to MBR, 11 ALU load, 12 ALU add, 13 ALU AND, 14 interrupt-enable clear. `mem_rd` is high exactly when bit 1 is high, `mem_wr` exactly when bit 8 is high. Opcodes: 0 load, 1 add, 2 AND, 3 store, 4 increment-and-skip-if-zero, 5 to 7 no operation. Phase codes: 0 fetch, 1 indirect, 2 execute, 3 interrupt.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: A synchronous reset puts the phase code at 0 (fetch) and the step at 1 on the next clock.
- R2: Fetch lasts 3 steps: step 1 raises gate 0; step 2 raises gates 1 and 2 with `mem_rd`; step 3 raises gate 3.
- R3: After fetch the phase becomes 1 (indirect) if `ind_bit` is high, else 2 (execute); indirect lasts 3 steps raising gate 4, then gate 1 with `mem_rd`, then gate 3, and is followed by execute.
- R4: Execute of opcodes 0, 1, 2 lasts 3 steps: gate 4, then gate 1 with `mem_rd`, then gate 11, 12 or 13 respectively.
- R5: Execute of opcode 3 lasts 3 steps: gate 4, then gate 10, then gate 8 with `mem_wr`.
- R6: Execute of opcode 4 lasts 4 steps: gate 4, then gate 1 with `mem_rd`, then gate 9, then gate 8 with `mem_wr`; in step 4 gate 2 is also raised when `mbr_zero` is high, and not otherwise.
- R7: Execute of opcodes 5 to 7 lasts one step with no gate and no strobe raised.
- R8: After execute the phase becomes 3 (interrupt) when `irq` and `ie_flag` are both high, else 0; a request with `ie_flag` low has no effect on the phase sequence.
- R9: Interrupt lasts 3 steps: gates 5 and 14, then gates 6 and 7, then gate 8 with `mem_wr`; it is followed by fetch.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.
- R11: The step restarts at 1 on every phase change and rises by exactly 1 per clock within a phase; gates not named for a step stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | OP_W | Opcode field of the instruction register |
| ind_bit | input | 1 | Instruction uses indirect addressing |
| irq | input | 1 | Interrupt request |
| ie_flag | input | 1 | Interrupt-enable flag held outside |
| mbr_zero | input | 1 | Memory buffer value is zero |
| cyc_code | output | 2 | Current phase code |
| step_num | output | STEP_W | Current timing step, from 1 |
| gate | output | 15 | Data-path gate enables |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The bench aims at phase boundaries: the variable-length execute phase (one, three and four steps), the indirect branch out of fetch, and an interrupt request arriving while the enable flag is clear, where a design ignoring the flag would enter the interrupt phase. It drives the increment-and-skip opcode with the zero flag both set and clear, so a controller that skipped unconditionally or never would show a wrong PC increment in step 4. A reset in the middle of an instruction checks that a stale step count does not survive, and a long pseudo-random instruction stream compares every gate against the reference model on every clock.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXE   = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  localparam int OP_LOAD  = 0;
  localparam int OP_ADD   = 1;
  localparam int OP_AND   = 2;
  localparam int OP_STORE = 3;
  localparam int OP_ISZ   = 4;

  localparam int G_PC_MAR   = 0;
  localparam int G_MEM_MBR  = 1;
  localparam int G_PC_INC   = 2;
  localparam int G_MBR_IR   = 3;
  localparam int G_IRA_MAR  = 4;
  localparam int G_PC_MBR   = 5;
  localparam int G_SAVE_MAR = 6;
  localparam int G_VEC_PC   = 7;
  localparam int G_MBR_MEM  = 8;
  localparam int G_MBR_INC  = 9;
  localparam int G_AC_MBR   = 10;
  localparam int G_ALU_LD   = 11;
  localparam int G_ALU_ADD  = 12;
  localparam int G_ALU_AND  = 13;
  localparam int G_IE_CLR   = 14;
  localparam int NUM_G      = 15;

  localparam int MAX_STEPS  = 4;

endpackage

// File: rtl/icc_op_decode.sv
module icc_op_decode #(
  parameter int OP_W = 3
) (
  input  logic [OP_W-1:0]      op_code,
  output logic [(1<<OP_W)-1:0] op_hot
);
  localparam int NUM_OPS = 1 << OP_W;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_dec
    assign op_hot[k] = (op_code == OP_W'(k));
  end

endmodule

// File: rtl/icc_timer.sv
module icc_timer
  import icc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_step,
  input  logic              ind_bit,
  input  logic              irq,
  input  logic              ie_flag,
  output cyc_e              cyc,
  output logic [STEP_W-1:0] step
);
  cyc_e nxt_cyc;

  always_comb begin
    unique case (cyc)
      CYC_FETCH: nxt_cyc = ind_bit ? CYC_IND : CYC_EXE;
      CYC_IND:   nxt_cyc = CYC_EXE;
      CYC_EXE:   nxt_cyc = (irq && ie_flag) ? CYC_INT : CYC_FETCH;
      default:   nxt_cyc = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= CYC_FETCH;
      step <= STEP_W'(1);
    end else if (last_step) begin
      cyc  <= nxt_cyc;
      step <= STEP_W'(1);
    end else begin
      step <= step + STEP_W'(1);
    end
  end

endmodule

// File: rtl/icc_matrix.sv
module icc_matrix
  import icc_pkg::*;
#(
  parameter int OP_W   = 3,
  parameter int STEP_W = 3
) (
  input  cyc_e                 cyc,
  input  logic [STEP_W-1:0]    step,
  input  logic [(1<<OP_W)-1:0] op_hot,
  input  logic                 mbr_zero,
  output logic [NUM_G-1:0]     gate,
  output logic                 last_step
);
  logic [MAX_STEPS-1:0] t;
  logic f, i, e, q;
  logic mem_op, sta, isz, nop;

  for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
    assign t[k] = (step == STEP_W'(k + 1));
  end

  assign f = (cyc == CYC_FETCH);
  assign i = (cyc == CYC_IND);
  assign e = (cyc == CYC_EXE);
  assign q = (cyc == CYC_INT);

  assign mem_op = op_hot[OP_LOAD] | op_hot[OP_ADD] | op_hot[OP_AND];
  assign sta    = op_hot[OP_STORE];
  assign isz    = op_hot[OP_ISZ];
  assign nop    = ~(mem_op | sta | isz);

  always_comb begin
    gate = '0;
    gate[G_PC_MAR]   = f & t[0];
    gate[G_MEM_MBR]  = t[1] & (f | i | (e & (mem_op | isz)));
    gate[G_PC_INC]   = (f & t[1]) | (e & isz & t[3] & mbr_zero);
    gate[G_MBR_IR]   = (f | i) & t[2];
    gate[G_IRA_MAR]  = t[0] & (i | (e & ~nop));
    gate[G_PC_MBR]   = q & t[0];
    gate[G_SAVE_MAR] = q & t[1];
    gate[G_VEC_PC]   = q & t[1];
    gate[G_MBR_MEM]  = (q & t[2]) | (e & sta & t[2]) | (e & isz & t[3]);
    gate[G_MBR_INC]  = e & isz & t[2];
    gate[G_AC_MBR]   = e & sta & t[1];
    gate[G_ALU_LD]   = e & op_hot[OP_LOAD] & t[2];
    gate[G_ALU_ADD]  = e & op_hot[OP_ADD] & t[2];
    gate[G_ALU_AND]  = e & op_hot[OP_AND] & t[2];
    gate[G_IE_CLR]   = q & t[0];
  end

  assign last_step = ((f | i | q) & t[2])
                   | (e & (((mem_op | sta) & t[2]) | (isz & t[3]) | (nop & t[0])));

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int OP_W   = 3,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_code,
  input  logic              ind_bit,
  input  logic              irq,
  input  logic              ie_flag,
  input  logic              mbr_zero,
  output logic [1:0]        cyc_code,
  output logic [STEP_W-1:0] step_num,
  output logic [NUM_G-1:0]  gate,
  output logic              mem_rd,
  output logic              mem_wr
);
  logic [(1<<OP_W)-1:0] op_hot;
  cyc_e                 cyc;
  logic [STEP_W-1:0]    step;
  logic                 last_step;

  icc_op_decode #(.OP_W(OP_W)) u_dec (
    .op_code (op_code),
    .op_hot  (op_hot)
  );

  icc_timer #(.STEP_W(STEP_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .last_step (last_step),
    .ind_bit   (ind_bit),
    .irq       (irq),
    .ie_flag   (ie_flag),
    .cyc       (cyc),
    .step      (step)
  );

  icc_matrix #(.OP_W(OP_W), .STEP_W(STEP_W)) u_mtx (
    .cyc       (cyc),
    .step      (step),
    .op_hot    (op_hot),
    .mbr_zero  (mbr_zero),
    .gate      (gate),
    .last_step (last_step)
  );

  assign cyc_code = cyc;
  assign step_num = step;
  assign mem_rd   = gate[G_MEM_MBR];
  assign mem_wr   = gate[G_MBR_MEM];

endmodule

// File: rtl/instr_cycle_ctrl_chk.sv
module instr_cycle_ctrl_chk #(
  parameter int OP_W   = 3,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_code,
  input logic              ind_bit,
  input logic              irq,
  input logic              ie_flag,
  input logic [1:0]        cyc_code,
  input logic [STEP_W-1:0] step_num,
  input logic              mem_rd,
  input logic              mem_wr
);

  // R10
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cyc_code == 2'b00 && step_num == STEP_W'(1)));

  // R11
  fetch_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_code == 2'b00 && step_num == STEP_W'(1)) |=>
      (cyc_code == 2'b00 && step_num == STEP_W'(2)));

  // R3
  ind_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_code == 2'b00 && step_num == STEP_W'(3) && ind_bit) |=>
      (cyc_code == 2'b01 && step_num == STEP_W'(1)));

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_code == 2'b10 && step_num == STEP_W'(1) && op_code == {OP_W{1'b1}}
     && irq && ie_flag) |=> (cyc_code == 2'b11 && step_num == STEP_W'(1)));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_code == 2'b10 && step_num == STEP_W'(1) && op_code == {OP_W{1'b1}}
     && !ie_flag) |=> (cyc_code == 2'b00 && step_num == STEP_W'(1)));

  // R9
  int_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_code == 2'b11 && step_num == STEP_W'(3)) |=>
      (cyc_code == 2'b00 && step_num == STEP_W'(1)));

  // R2
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (step_num == STEP_W'(2)));

endmodule

bind instr_cycle_ctrl instr_cycle_ctrl_chk #(.OP_W(OP_W), .STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_code  (op_code),
  .ind_bit  (ind_bit),
  .irq      (irq),
  .ie_flag  (ie_flag),
  .cyc_code (cyc_code),
  .step_num (step_num),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/instr_cycle_ctrl_tb.sv
module instr_cycle_ctrl_tb;
  localparam int OP_W   = 3;
  localparam int STEP_W = 3;
  localparam int NG     = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [OP_W-1:0]   op_code = '0;
  logic              ind_bit = 1'b0;
  logic              irq = 1'b0;
  logic              ie_flag = 1'b0;
  logic              mbr_zero = 1'b0;
  logic [1:0]        cyc_code;
  logic [STEP_W-1:0] step_num;
  logic [NG-1:0]     gate;
  logic              mem_rd;
  logic              mem_wr;

  int checks = 0;
  int errors = 0;
  int m_cyc  = 0;
  int m_step = 1;
  bit finished = 0;

  instr_cycle_ctrl #(.OP_W(OP_W), .STEP_W(STEP_W)) u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .ind_bit(ind_bit), .irq(irq),
    .ie_flag(ie_flag), .mbr_zero(mbr_zero), .cyc_code(cyc_code),
    .step_num(step_num), .gate(gate), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  always #10 clk = ~clk;

  // Number of steps in a phase
  function automatic int phase_len(int c, int op);
    if (c != 2) return 3;
    if (op <= 3) return 3;
    if (op == 4) return 4;
    return 1;
  endfunction

  // Expected gates for phase c, step s
  function automatic logic [NG-1:0] exp_gates(int c, int s, int op, bit z);
    logic [NG-1:0] b = '0;
    if (c == 0) begin
      if (s == 1) b[0] = 1;
      if (s == 2) begin b[1] = 1; b[2] = 1; end
      if (s == 3) b[3] = 1;
    end else if (c == 1) begin
      if (s == 1) b[4] = 1;
      if (s == 2) b[1] = 1;
      if (s == 3) b[3] = 1;
    end else if (c == 3) begin
      if (s == 1) begin b[5] = 1; b[14] = 1; end
      if (s == 2) begin b[6] = 1; b[7] = 1; end
      if (s == 3) b[8] = 1;
    end else if (op <= 2) begin
      if (s == 1) b[4] = 1;
      if (s == 2) b[1] = 1;
      if (s == 3) b[11 + op] = 1;
    end else if (op == 3) begin
      if (s == 1) b[4] = 1;
      if (s == 2) b[10] = 1;
      if (s == 3) b[8] = 1;
    end else if (op == 4) begin
      if (s == 1) b[4] = 1;
      if (s == 2) b[1] = 1;
      if (s == 3) b[9] = 1;
      if (s == 4) begin b[8] = 1; b[2] = z; end
    end
    return b;
  endfunction

  function automatic string gate_tag(int c, int op);
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    if (c == 3) return "R9";
    if (op <= 2) return "R4";
    if (op == 3) return "R5";
    if (op == 4) return "R6";
    return "R7";
  endfunction

  function automatic string seq_tag(int c, int s);
    if (c == 3 && s == 1) return "R8";
    if (c == 1 && s == 1) return "R3";
    return "R11";
  endfunction

  // One clock: compare at mid-cycle, advance model, wait for next mid-cycle
  task automatic tick();
    logic [NG-1:0] eg;
    bit clr;
    #1;
    eg  = exp_gates(m_cyc, m_step, int'(op_code), mbr_zero);
    clr = eg[14];
    checks++;
    if (int'(cyc_code) != m_cyc || int'(step_num) != m_step) begin
      errors++;
      $display("FAIL %s phase/step actual %0d/%0d expected %0d/%0d",
               seq_tag(m_cyc, m_step), cyc_code, step_num, m_cyc, m_step);
    end
    checks++;
    if (gate !== eg || mem_rd !== eg[1] || mem_wr !== eg[8]) begin
      errors++;
      $display("FAIL %s gates actual %h rd %b wr %b expected %h rd %b wr %b",
               gate_tag(m_cyc, int'(op_code)), gate, mem_rd, mem_wr, eg, eg[1], eg[8]);
    end
    checks++;
    if (mem_rd && mem_wr) begin
      errors++;
      $display("FAIL R10 strobes actual rd %b wr %b expected not both", mem_rd, mem_wr);
    end
    if (m_step == phase_len(m_cyc, int'(op_code))) begin
      case (m_cyc)
        0: m_cyc = ind_bit ? 1 : 2;
        1: m_cyc = 2;
        2: m_cyc = (irq && ie_flag) ? 3 : 0;
        default: m_cyc = 0;
      endcase
      m_step = 1;
    end else begin
      m_step++;
    end
    @(negedge clk);
    if (clr) ie_flag = 1'b0;
  endtask

  task automatic run_instr(int op, bit ind, bit rq, bit ie, bit z);
    op_code  = OP_W'(op);
    ind_bit  = ind;
    irq      = rq;
    ie_flag  = ie;
    mbr_zero = z;
    for (int n = 0; n < 20; n++) begin
      tick();
      if (m_cyc == 0 && m_step == 1) break;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cyc = 0;
    m_step = 1;
    #1;
    checks++;
    if (cyc_code !== 2'b00 || step_num !== STEP_W'(1)) begin
      errors++;
      $display("FAIL R1 reset state actual %0d/%0d expected 0/1", cyc_code, step_num);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    do_reset();                     // R1
    run_instr(0, 0, 0, 0, 0);       // R2 R4 load
    run_instr(1, 1, 0, 0, 0);       // R3 add indirect
    run_instr(2, 0, 0, 0, 0);       // R4 AND
    run_instr(3, 0, 0, 0, 0);       // R5 store
    run_instr(4, 0, 0, 0, 0);       // R6 no skip
    run_instr(4, 0, 0, 0, 1);       // R6 skip
    run_instr(5, 0, 0, 0, 0);       // R7
    run_instr(7, 0, 1, 0, 0);       // R8 masked request
    run_instr(7, 0, 1, 1, 0);       // R8 R9 taken
    run_instr(4, 1, 1, 1, 1);       // R6 R9 indirect then interrupt
    op_code = 3'd4;
    tick(); tick(); tick(); tick(); // mid-instruction
    do_reset();                     // R1 mid-run reset
    for (int n = 0; n < 60; n++) begin
      run_instr(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule